// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous request port and an asynchronous 32768 x 8 static RAM. It has active-low select, output-enable and write-strobe pins and a shared data bus. A user issues one word per request over a valid/ready handshake, with a direction bit, a 15-bit address and, for stores, an 8-bit datum. The controller then plays out the strobe sequence the RAM needs and returns loaded data with a single-cycle response pulse.

Every access window is a whole number of clock cycles. The count is worked out at elaboration from the clock period and the minimum nanosecond figures of the memory. Each figure is divided by the period, rounded up, and never allowed below one cycle. The data bus is split at the block boundary into an outgoing value, a driver enable and an incoming value, so the pad or the test model resolves the shared wire. The controller holds its own driver off until the memory has certainly stopped driving after the write strobe falls. It keeps the output-enable pin high for the whole of a store.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and until the first accepted request, the select, output-enable and write strobes are all high (1), the bus driver enable is low and `req_ready` is high.
- R2: A load holds select and output-enable low, with the write strobe high, for RD_CYC = max(1, ceil(max(T_AA_NS, T_RC_NS)/CLK_NS)) cycles. The first of these cycles is the one right after acceptance. The bus value present in the last of them is returned on `rsp_rdata`, with `rsp_valid` high for exactly the single following cycle.
- R3: A store holds select low with the write strobe high for one setup cycle. It then holds the write strobe low for WP_CYC = max(ceil(T_WP_NS/CLK_NS), DRV_DLY + ceil(T_DW_NS/CLK_NS), ceil(T_WC_NS/CLK_NS) - 1) cycles. Output-enable stays high throughout, and the word lands at the requested address.
- R4: The RAM address never changes in a cycle where select and the write strobe were both low in the previous cycle and are still both low.
- R5: The bus driver turns on only after the write strobe has been low for DRV_DLY = max(1, ceil(T_WZ_NS/CLK_NS)) cycles. It stays on through the cycle in which the strobe rises, and it never overlaps a cycle in which the RAM may drive (select and output-enable low with the write strobe high).
- R6: `req_ready` is low from acceptance until the access and its turnaround cycle are over. It returns RD_CYC + 2 cycles after a load is accepted and WP_CYC + 3 cycles after a store is accepted, so a load is always followed by one idle cycle before a store can start.
- R7: Requests at the extremes of the address range (0x0000 and 0x7FFF) and at alternating-bit addresses reach distinct words, and a later store to an address replaces the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Store datum |
| rsp_valid | output | 1 | One-cycle pulse marking load data |
| rsp_rdata | output | 8 | Loaded word |
| sram_addr | output | 15 | RAM address pins |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_dq_out | output | 8 | Value the controller drives on the data bus |
| sram_dq_oe | output | 1 | Controller bus driver enable |
| sram_dq_in | input | 8 | Resolved data bus value |

## Verification
The bench builds the controller with a 4 ns period, 10 ns access, cycle and pulse minima, a 7 ns data setup and a 5 ns strobe-to-release figure. This gives RD_CYC = 3, DRV_DLY = 2 and WP_CYC = 4. The store pulse is therefore stretched by the release wait, not set by the bare pulse minimum, and that term becomes observable. The memory model only returns the true word once a read has been steady for three cycles. An early capture shows up as a wrong value. The model also counts address motion inside the store window and any overlap of the controller's driver with the memory's own drive or release window.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_NS  = 4,
  parameter int T_AA_NS = 10,
  parameter int T_RC_NS = 10,
  parameter int T_WP_NS = 10,
  parameter int T_WC_NS = 10,
  parameter int T_DW_NS = 7,
  parameter int T_WZ_NS = 3,
  parameter int AW      = 15,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = cyc(imax(T_AA_NS, T_RC_NS));
  localparam int DRV_DLY = cyc(T_WZ_NS);
  localparam int WP_CYC  = imax(imax(cyc(T_WP_NS), DRV_DLY + cyc(T_DW_NS)), cyc(T_WC_NS) - 1);
  localparam int CNT_W   = $clog2(imax(RD_CYC, WP_CYC) + 1);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC);
  localparam logic [CNT_W-1:0] DRV_AT   = CNT_W'(DRV_DLY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RD_GAP, S_WSET, S_WPUL, S_WREL} state_t;

  state_t          st;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sram_addr   <= '0;
      sram_cs_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          sram_addr <= req_addr;
          sram_cs_n <= 1'b0;
          cnt       <= CNT_ONE;
          if (req_write) begin
            sram_dq_out <= req_wdata;
            st          <= S_WSET;
          end else begin
            sram_oe_n <= 1'b0;
            st        <= S_RD;
          end
        end
        S_RD: if (cnt == RD_LAST) begin
          rsp_rdata <= sram_dq_in;
          rsp_valid <= 1'b1;
          sram_cs_n <= 1'b1;
          sram_oe_n <= 1'b1;
          st        <= S_RD_GAP;
        end else begin
          cnt <= cnt + CNT_ONE;
        end
        S_RD_GAP: st <= S_IDLE;
        S_WSET: begin
          sram_we_n <= 1'b0;
          cnt       <= CNT_ONE;
          st        <= S_WPUL;
        end
        S_WPUL: begin
          if (cnt == DRV_AT) sram_dq_oe <= 1'b1;
          if (cnt == WP_LAST) begin
            sram_we_n <= 1'b1;
            sram_cs_n <= 1'b1;
            st        <= S_WREL;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        S_WREL: begin
          sram_dq_oe <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !sram_we_n) |=> ((sram_cs_n || sram_we_n) || $stable(sram_addr))); // R4
  AST_OE_HIGH_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_cs_n)); // R3
  AST_DRIVE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !$past(sram_we_n))); // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe)); // R6
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!sram_oe_n && !sram_cs_n)); // R2

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
  localparam int RD_EXP  = 3;
  localparam int WP_EXP  = 4;
  localparam int DRV_EXP = 2;
  localparam int WZ_EXP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] sram_addr;
  logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  always #2 clk = ~clk;

  sram_async_ctrl #(.CLK_NS(4), .T_AA_NS(10), .T_RC_NS(10), .T_WP_NS(10),
                    .T_WC_NS(10), .T_DW_NS(7), .T_WZ_NS(5)) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in));

  // memory model
  logic [7:0] mem [logic [14:0]];
  logic [7:0] dev_data = 8'h00;
  wire        dev_on = !sram_cs_n && !sram_oe_n && sram_we_n;
  assign sram_dq_in = sram_dq_oe ? sram_dq_out : (dev_on ? dev_data : 8'h5A);

  int addr_viol = 0, contention = 0, oe_in_store = 0;
  int we_run = 0, drv_run = 0, rd_run = 0, last_wp = 0, last_drv = 0;
  logic        prev_both = 1'b0, prev_dev = 1'b0;
  logic [14:0] prev_addr = '0;
  logic [7:0]  prev_bus = '0;

  function automatic logic [7:0] peek(input logic [14:0] a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(negedge clk) begin
    logic both;
    both = !sram_cs_n && !sram_we_n;
    if (both && prev_both && sram_addr != prev_addr) addr_viol++;
    if (dev_on && sram_dq_oe) contention++;
    if (!sram_we_n && !sram_oe_n) oe_in_store++;
    if (both) begin
      we_run++;
      if (sram_dq_oe) drv_run++; else drv_run = 0;
      if (sram_dq_oe && we_run <= WZ_EXP) contention++;
    end
    if (prev_both && !both) begin
      mem[prev_addr] = prev_bus;
      last_wp = we_run; last_drv = drv_run;
      we_run = 0; drv_run = 0;
    end
    if (dev_on) begin
      rd_run = (prev_dev && sram_addr == prev_addr) ? rd_run + 1 : 1;
      dev_data = (rd_run >= RD_EXP) ? peek(sram_addr) : ~peek(sram_addr);
    end else rd_run = 0;
    prev_both = both; prev_dev = dev_on;
    prev_addr = sram_addr; prev_bus = sram_dq_in;
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    lat = 1;
    while (!req_ready) begin @(negedge clk); lat++; end
  endtask

  task automatic do_read(input logic [14:0] a, output logic [7:0] d, output int lat,
                         output logic gap_ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    d = rsp_rdata;
    gap_ok = !req_ready;
    @(negedge clk);
    gap_ok = gap_ok && req_ready && !rsp_valid;
  endtask

  task automatic t_reset;
    chk("R1 cs_n", int'(sram_cs_n), 1);
    chk("R1 oe_n", int'(sram_oe_n), 1);
    chk("R1 we_n", int'(sram_we_n), 1);
    chk("R1 dq_oe", int'(sram_dq_oe), 0);
    chk("R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_basic;
    int lat; logic [7:0] d; logic g;
    do_write(15'h1234, 8'hA5, lat);
    chk("R6 store ready latency", lat, WP_EXP + 3);
    chk("R3 strobe low cycles", last_wp, WP_EXP);
    chk("R5 driven cycles before strobe rise", last_drv, DRV_EXP);
    do_read(15'h1234, d, lat, g);
    chk("R2 load data", int'(d), 'hA5);
    chk("R2 response latency", lat, RD_EXP + 1);
    chk("R6 load turnaround and single pulse", int'(g), 1);
  endtask

  task automatic t_patterns;
    int lat; logic [7:0] d; logic g;
    do_write(15'h0000, 8'h11, lat);
    do_write(15'h7FFF, 8'hEE, lat);
    do_write(15'h5555, 8'h3C, lat);
    do_write(15'h2AAA, 8'hC3, lat);
    do_read(15'h0000, d, lat, g); chk("R7 addr 0000", int'(d), 'h11);
    do_read(15'h7FFF, d, lat, g); chk("R7 addr 7FFF", int'(d), 'hEE);
    do_read(15'h5555, d, lat, g); chk("R7 addr 5555", int'(d), 'h3C);
    do_read(15'h2AAA, d, lat, g); chk("R7 addr 2AAA", int'(d), 'hC3);
  endtask

  task automatic t_overwrite_turnaround;
    int lat; logic [7:0] d; logic g;
    do_read(15'h0042, d, lat, g);
    chk("R2 unwritten word", int'(d), 'hFF);
    do_write(15'h0042, 8'h01, lat);
    do_write(15'h0042, 8'h80, lat);
    do_read(15'h0042, d, lat, g);
    chk("R7 overwrite", int'(d), 'h80);
    for (int i = 0; i < 4; i++) begin
      do_write(15'(16'h0100 + i), 8'(i * 37), lat);
      do_read(15'(16'h0100 + i), d, lat, g);
      chk("R3 back-to-back store/load", int'(d), (i * 37) & 'hFF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", int'(req_ready), 1);
    t_basic;
    t_patterns;
    t_overwrite_turnaround;
    chk("R4 address moves in store window", addr_viol, 0);
    chk("R5 bus contention", contention, 0);
    chk("R3 output enable low during store", oe_in_store, 0);
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule